// File: doc/BRIEF.md
# Timer-Driven PWM Channel with Buffered Duty

This block produces one pulse-width-modulated output from its own timebase. The input clock is divided by four and then by a selectable prescale ratio, and the result advances a counter. The counter runs from zero up to a programmable period limit and then wraps. At each wrap the output goes high and a new duty value is taken from a shadow register. The output goes low once the counter reaches that duty value. A sticky flag marks every wrap, and software clears it by pulsing a clear strobe.

Software sets the block up through a small write port that has three addresses. Two power inputs stop the block. A sleep request freezes everything. An idle request freezes the block only when one of two stop-in-idle bits is set: one belongs to the timer and one to the output stage. While the block is frozen the output keeps its level, and the period is stretched by exactly the number of frozen cycles.

Top module: `ocpwm_top`

## Requirements
- R1: With prescale select 0, the wrap flag rises exactly once every (P+1)*4 clocks, where P is the period register.
- R2: For a duty value D with 0 < D <= P, the output is high for exactly D*4*ratio clocks in each period, starting at the wrap.
- R3: A duty value of 0 keeps the output low for the whole period.
- R4: A duty value greater than P keeps the output high for the whole period.
- R5: A duty value written during a period has no effect on that period and applies from the next wrap onward.
- R6: The wrap flag is set at each wrap and stays set until a clear strobe arrives; a strobe with no wrap in the same cycle clears it.
- R7: When a clear strobe and a wrap fall in the same cycle, the flag ends up set.
- R8: While sleep_req is high, counting stops and the output holds its level; the period grows by the number of sleep cycles.
- R9: While idle_req is high, the block runs unchanged if both stop-in-idle bits are 0, and freezes like sleep if either bit is 1.
- R10: While the enable bit is 0, the output is low and the counters are cleared. One clock after enable, the output is high if and only if the duty value loaded at enable is nonzero.
- R11: The control word uses bit 0 for enable, bits 2:1 for the prescale select (0/1/2/3 giving ratios 1/8/64/256), bit 3 for timer stop-in-idle and bit 4 for output stop-in-idle. Address 0 holds the period, address 1 the shadow duty value and address 2 the control word. With ratio r the period is (P+1)*4*r clocks.
- R12: After reset the output and the flag are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 period, 1 duty shadow, 2 control) |
| wr_data | input | WIDTH | Write data |
| flag_clr | input | 1 | Clear strobe for the wrap flag |
| sleep_req | input | 1 | Freeze request for sleep |
| idle_req | input | 1 | Idle request, which takes effect only through the stop bits |
| pwm_out | output | 1 | PWM output |
| period_flag | output | 1 | Sticky wrap flag |

## Verification
Two cases are the hardest to reach from the ports. The first is a clear strobe that lands in the very cycle of a wrap. The bench reaches it by holding the clear strobe high for an entire period, which forces one pulse to coincide with the wrap. The second is a freeze in the middle of the high phase. The bench raises sleep or idle one cycle after a detected wrap and holds it for 40 clocks. It then counts the high samples over the stretched window, which must equal the normal high time plus the freeze length. The duty and period sweep covers every duty value from 0 to P+2 for small periods, which exercises both saturation cases and every prescale ratio.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;

  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam int         CTRL_BITS   = 5;

  typedef struct packed {
    logic       out_idle_stop;
    logic       tmr_idle_stop;
    logic [1:0] ps_sel;
    logic       enable;
  } ctrl_t;

  // terminal count of the prescaler for each select code
  function automatic logic [7:0] ps_last(input logic [1:0] sel);
    case (sel)
      2'd0:    ps_last = 8'd0;
      2'd1:    ps_last = 8'd7;
      2'd2:    ps_last = 8'd63;
      default: ps_last = 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/ocpwm_regs.sv
module ocpwm_regs
  import ocpwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] period_q,
  output logic [WIDTH-1:0] shadow_q,
  output ctrl_t            ctrl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      shadow_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD: period_q <= wr_data;
        ADDR_DUTY:   shadow_q <= wr_data;
        ADDR_CTRL:   ctrl_q   <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
        default:     ;
      endcase
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q)); // R11

endmodule

// File: rtl/ocpwm_tick.sv
module ocpwm_tick
  import ocpwm_pkg::*;
#(
  parameter int QBITS = 2,
  parameter int PSW   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       run,
  input  logic [1:0] ps_sel,
  output logic       tick
);

  logic [PSW-1:0] ps_cnt;
  logic [PSW-1:0] ps_lim;
  logic           qwrap;

  assign ps_lim = PSW'(ps_last(ps_sel));

  generate
    if (QBITS > 0) begin : g_quarter
      logic [QBITS-1:0] qcnt;
      always_ff @(posedge clk) begin
        if (rst || !en) qcnt <= '0;
        else if (run)   qcnt <= qcnt + 1'b1;
      end
      assign qwrap = &qcnt;
    end else begin : g_direct
      assign qwrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ps_cnt <= '0;
    end else if (run && qwrap) begin
      if (ps_cnt == ps_lim) ps_cnt <= '0;
      else                  ps_cnt <= ps_cnt + 1'b1;
    end
  end

  assign tick = run && qwrap && (ps_cnt == ps_lim);

  generate
    if (QBITS > 0) begin : g_chk
      AST_NO_TICK_AFTER_DIS: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick); // R10
    end
  endgenerate

endmodule

// File: rtl/ocpwm_timebase.sv
module ocpwm_timebase #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [WIDTH-1:0] period,
  output logic [WIDTH-1:0] tmr,
  output logic             wrap
);

  assign wrap = tick && (tmr == period);

  always_ff @(posedge clk) begin
    if (rst || !en)  tmr <= '0;
    else if (wrap)   tmr <= '0;
    else if (tick)   tmr <= tmr + 1'b1;
  end

  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (tmr == '0)); // R1
  AST_TMR_STILL: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(tmr)); // R8

endmodule

// File: rtl/ocpwm_compare.sv
module ocpwm_compare #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap,
  input  logic [WIDTH-1:0] tmr,
  input  logic [WIDTH-1:0] shadow,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic             flag
);

  logic [WIDTH-1:0] active;
  logic             armed;
  logic [WIDTH:0]   tmr_next;

  assign tmr_next = {1'b0, tmr} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (wrap) begin
      flag <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= '0;
      pwm_out <= 1'b0;
      armed   <= 1'b1;
    end else if (!en) begin
      active  <= shadow;
      pwm_out <= 1'b0;
      armed   <= 1'b1;
    end else if (run) begin
      if (armed) begin
        pwm_out <= (active != '0);
        armed   <= 1'b0;
      end else if (wrap) begin
        active  <= shadow;
        pwm_out <= (shadow != '0);
      end else if (tick && (tmr_next == {1'b0, active})) begin
        pwm_out <= 1'b0;
      end
    end
  end

  AST_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out); // R10
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag); // R7
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !wrap) |=> !flag); // R6
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (wrap && shadow == '0) |=> !pwm_out); // R3
  AST_OVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wrap && shadow > tmr) |=> pwm_out); // R4

endmodule

// File: rtl/ocpwm_top.sv
module ocpwm_top
  import ocpwm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int QBITS = 2,
  parameter int PSW   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             flag_clr,
  input  logic             sleep_req,
  input  logic             idle_req,
  output logic             pwm_out,
  output logic             period_flag
);

  logic [WIDTH-1:0] period_q;
  logic [WIDTH-1:0] shadow_q;
  ctrl_t            ctrl_q;
  logic             run;
  logic             idle_stop;
  logic             tick;
  logic             wrap;
  logic [WIDTH-1:0] tmr;

  assign idle_stop = idle_req && (ctrl_q.tmr_idle_stop || ctrl_q.out_idle_stop);
  assign run       = ctrl_q.enable && !sleep_req && !idle_stop;

  ocpwm_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .period_q (period_q),
    .shadow_q (shadow_q),
    .ctrl_q   (ctrl_q)
  );

  ocpwm_tick #(.QBITS(QBITS), .PSW(PSW)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .en     (ctrl_q.enable),
    .run    (run),
    .ps_sel (ctrl_q.ps_sel),
    .tick   (tick)
  );

  ocpwm_timebase #(.WIDTH(WIDTH)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .en     (ctrl_q.enable),
    .tick   (tick),
    .period (period_q),
    .tmr    (tmr),
    .wrap   (wrap)
  );

  ocpwm_compare #(.WIDTH(WIDTH)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_q.enable),
    .run      (run),
    .tick     (tick),
    .wrap     (wrap),
    .tmr      (tmr),
    .shadow   (shadow_q),
    .flag_clr (flag_clr),
    .pwm_out  (pwm_out),
    .flag     (period_flag)
  );

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && ctrl_q.enable) |=> $stable(pwm_out)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idle_stop && ctrl_q.enable) |=> ($stable(pwm_out) && $stable(tmr))); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!pwm_out && !period_flag)); // R12

endmodule

// File: tb/sim_ocpwm_top.sv
module sim_ocpwm_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         flag_clr = 1'b0;
  logic         sleep_req = 1'b0;
  logic         idle_req = 1'b0;
  logic         pwm_out;
  logic         period_flag;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ocpwm_top #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_clr(flag_clr), .sleep_req(sleep_req), .idle_req(idle_req),
    .pwm_out(pwm_out), .period_flag(period_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ratio(input int ps);
    case (ps)
      0: ratio = 1;
      1: ratio = 8;
      2: ratio = 64;
      default: ratio = 256;
    endcase
  endfunction

  // disable, load, enable, then wait until the first wrap is visible
  task automatic start(input int pr, input int duty, input int ps, input int stops);
    int k;
    wr(2'd2, '0);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(pwm_out == 1'b0, "R10 disabled output", pwm_out, 0);
    wr(2'd0, W'(pr));
    wr(2'd1, W'(duty));
    wr(2'd2, W'((stops << 3) | (ps << 1) | 1));
    @(negedge clk);
    chk(pwm_out == (duty != 0), "R10 output after enable", pwm_out, (duty != 0));
    k = 0;
    while (!period_flag && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(period_flag == 1'b1, "R6 first wrap seen", period_flag, 1);
  endtask

  // sample from the current negedge (first sample just after a wrap)
  task automatic measure(input int win, input int sfrom, input int slen, input int kind,
                         input int wat, input logic [W-1:0] wval, input bit hold,
                         output int hi, output int early);
    bit st;
    hi = 0; early = 0;
    for (int i = 0; i < win; i++) begin
      if (pwm_out) hi++;
      if (i > 0 && period_flag) early++;
      flag_clr  = hold || (i == 0);
      st        = (i >= sfrom) && (i < sfrom + slen);
      sleep_req = (kind == 1) && st;
      idle_req  = (kind == 2) && st;
      wr_en     = (i == wat);
      wr_addr   = 2'd1;
      wr_data   = wval;
      @(negedge clk);
    end
    sleep_req = 1'b0; idle_req = 1'b0; wr_en = 1'b0;
    flag_clr  = hold;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int hi, early, n, exph;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R12 reset output", pwm_out, 0);
    chk(period_flag == 1'b0, "R12 reset flag", period_flag, 0);

    // sweep with ratio 1: R1, R2, R3, R4
    for (int pr = 0; pr <= 4; pr++) begin
      for (int d = 0; d <= pr + 2; d++) begin
        start(pr, d, 0, 0);
        n = (pr + 1) * 4;
        exph = ((d < pr + 1) ? d : pr + 1) * 4;
        tag = (d == 0) ? "R3 high time" : ((d > pr) ? "R4 high time" : "R2 high time");
        measure(n, -1, 0, 0, -1, '0, 1'b0, hi, early);
        chk(hi == exph, tag, hi, exph);
        chk(early == 0, "R1 no early wrap", early, 0);
        chk(period_flag == 1'b1, "R1 wrap at period end", period_flag, 1);
      end
    end

    // other prescale ratios: R11
    for (int ps = 1; ps <= 3; ps++) begin
      for (int d = 0; d <= 2; d++) begin
        start(1, d, ps, 0);
        n = 2 * 4 * ratio(ps);
        exph = ((d < 2) ? d : 2) * 4 * ratio(ps);
        measure(n, -1, 0, 0, -1, '0, 1'b0, hi, early);
        chk(hi == exph, "R11 prescaled high time", hi, exph);
        chk(early == 0, "R11 no early wrap", early, 0);
        chk(period_flag == 1'b1, "R11 prescaled period", period_flag, 1);
      end
    end

    // R5: mid-period duty write is deferred
    start(7, 2, 0, 0);
    measure(32, -1, 0, 0, 5, W'(6), 1'b0, hi, early);
    chk(hi == 8, "R5 current period unchanged", hi, 8);
    chk(period_flag == 1'b1, "R5 wrap", period_flag, 1);
    measure(32, -1, 0, 0, -1, '0, 1'b0, hi, early);
    chk(hi == 24, "R5 next period uses new duty", hi, 24);

    // R6: flag sticks with no clear
    flag_clr = 1'b0;
    repeat (70) @(negedge clk);
    chk(period_flag == 1'b1, "R6 flag sticky", period_flag, 1);

    // R7: clear held across the wrap
    start(2, 1, 0, 0);
    measure(12, -1, 0, 0, -1, '0, 1'b1, hi, early);
    chk(early == 0, "R7 flag cleared while held", early, 0);
    chk(period_flag == 1'b1, "R7 set wins over clear", period_flag, 1);
    flag_clr = 1'b0;

    // R8: sleep freezes during high phase
    start(3, 2, 0, 0);
    measure(56, 1, 40, 1, -1, '0, 1'b0, hi, early);
    chk(hi == 48, "R8 output held in sleep", hi, 48);
    chk(early == 0, "R8 no wrap in sleep", early, 0);
    chk(period_flag == 1'b1, "R8 stretched period", period_flag, 1);

    // R9: idle with both stop bits clear runs on
    start(3, 2, 0, 0);
    measure(16, 1, 40, 2, -1, '0, 1'b0, hi, early);
    chk(hi == 8, "R9 idle runs", hi, 8);
    chk(period_flag == 1'b1, "R9 idle period", period_flag, 1);
    // R9: each stop bit freezes
    for (int s = 1; s <= 2; s++) begin
      start(3, 2, 0, s);
      measure(56, 1, 40, 2, -1, '0, 1'b0, hi, early);
      chk(hi == 48, "R9 idle stop holds", hi, 48);
      chk(early == 0, "R9 no wrap in idle", early, 0);
      chk(period_flag == 1'b1, "R9 idle stretched period", period_flag, 1);
    end

    // R10: disable forces low
    wr(2'd2, '0);
    repeat (20) begin
      @(negedge clk);
      chk(pwm_out == 1'b0, "R10 low while disabled", pwm_out, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule